// File: doc/BRIEF.md
# Read-Priority 32x8 Static RAM

A small static memory of 32 bytes that sits on a shared bidirectional 8-bit data bus. Three active-low controls govern it: a chip select, a read strobe that also enables the bus drivers, and a write strobe. Read data comes straight from the current address through combinational logic, with no precharge or clock phase. Writes are captured on the rising edge of a system clock.

When both strobes are asserted together, the read wins and the write is dropped. This is the reverse of the usual SRAM convention. A processor can therefore leave the write strobe low through a read cycle without corrupting the array.

Internally the bus is split into a data-in path, a data-out path and a drive-enable flag. A thin top-level wrapper turns these into tri-state pads. The drive-enable flag is also brought out as a port, so the surrounding logic can tell when the memory owns the bus.

Top module: `sram32x8`

## Requirements
- R1: The array holds 32 independent 8-bit words, selected by a 5-bit word address `addr[4:0]`. Every address stores and returns its own value, with no aliasing between addresses.
- R2: A write takes place on a rising `clk` edge when `cs_n`=0, `rd_n`=1 and `wr_n`=0. The word on `data` is stored at `addr`, and the block does not drive the bus during the write.
- R3: While `cs_n`=1, `drv_on` is 0, the bus is released, and no strobe changes any stored word.
- R4: While `cs_n`=0 and `rd_n`=0, the word stored at `addr` is driven on `data` whatever the level of `wr_n`. Read data follows a change of `addr` in the same cycle, with no clock edge needed.
- R5: While `rd_n`=0, no stored word changes, even if `wr_n`=0 and a clock edge occurs.
- R6: With `cs_n`=0 and `rd_n`=`wr_n`=1 (standby), `drv_on` is 0 and no stored word changes.
- R7: A read of an address in the cycle after that address was written returns the newly written value.
- R8: `drv_on` is 1 exactly when `cs_n`=0 and `rd_n`=0. The block drives `data` only in that state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which writes are captured |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe and output enable, active low; has priority over the write strobe |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 5 | Word address |
| data | inout | 8 | Shared data bus |
| drv_on | output | 1 | High while the block drives `data` |

## Verification
The assertions assume that the controls and the address are stable around each rising clock edge. They also assume that, when the block does not drive the bus, the bus carries a defined value from outside. The bench meets both assumptions by changing every input on the falling edge. It drives the bus itself only while `drv_on` is low, and it keeps the bus driven with a defined word through every write and standby cycle. The array is never read before it has been written, because reset does not clear it.

// File: rtl/sram32x8_core.sv
module sram32x8_core #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          oe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          sel, we;

  assign sel  = ~cs_n;
  assign oe   = sel & ~rd_n;
  assign we   = sel & rd_n & ~wr_n;
  assign dout = mem[addr];

  always_ff @(posedge clk)
    if (we) mem[addr] <= din;
endmodule

// File: rtl/sram32x8.sv
module sram32x8 #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  wire           clk,
  input  wire           cs_n,
  input  wire           rd_n,
  input  wire           wr_n,
  input  wire  [AW-1:0] addr,
  inout  wire  [DW-1:0] data,
  output wire           drv_on
);
  wire [DW-1:0] rdata;

  sram32x8_core #(.AW(AW), .DW(DW)) u_core (
    .clk (clk),
    .cs_n(cs_n),
    .rd_n(rd_n),
    .wr_n(wr_n),
    .addr(addr),
    .din (data),
    .dout(rdata),
    .oe  (drv_on)
  );

  assign data = drv_on ? rdata : {DW{1'bz}};
endmodule

// File: rtl/sram32x8_chk.sv
module sram32x8_chk #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] din,
  input logic [DW-1:0] dout,
  input logic          oe,
  input logic [DW-1:0] mem [1<<AW]
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R2: a qualified write lands at the sampled address
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!started)
    (!cs_n && rd_n && !wr_n) |=> mem[$past(addr)] == $past(din));

  // R3: deselected, the addressed word is untouched
  assert_deselect_holds_R3: assert property (@(posedge clk) disable iff (!started)
    cs_n |=> mem[$past(addr)] == $past(mem[addr]));

  // R4: while enabled, the output carries the stored word
  assert_read_data_R4: assert property (@(posedge clk) disable iff (!started)
    oe |-> dout == mem[addr]);

  // R5: read strobe low blocks any update
  assert_read_blocks_write_R5: assert property (@(posedge clk) disable iff (!started)
    !rd_n |=> mem[$past(addr)] == $past(mem[addr]));

  // R6: standby leaves the array alone
  assert_standby_holds_R6: assert property (@(posedge clk) disable iff (!started)
    (!cs_n && rd_n && wr_n) |=> mem[$past(addr)] == $past(mem[addr]));

  // R8: never drive while deselected or with read strobe high
  always_comb
    if (started) assert_no_drive_idle_R8: assert (!(oe && (cs_n || rd_n)));
endmodule

bind sram32x8_core sram32x8_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk (clk),
  .cs_n(cs_n),
  .rd_n(rd_n),
  .wr_n(wr_n),
  .addr(addr),
  .din (din),
  .dout(dout),
  .oe  (oe),
  .mem (mem)
);

// File: tb/tb_sram32x8.sv
`timescale 1ns/1ps
module tb_sram32x8;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          tb_en = 1'b1;
  logic [DW-1:0] tb_val = '0;
  wire  [DW-1:0] data;
  wire           drv_on;
  int            errors = 0, checks = 0;

  always #4 clk = ~clk;

  assign data = tb_en ? tb_val : {DW{1'bz}};

  sram32x8 #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data(data), .drv_on(drv_on)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    tb_en = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    tb_en = 1'b1; tb_val = d; addr = a;
    cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
    #1 check("R2 no drive during write", {7'b0, drv_on}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; cs_n = 1'b0; wr_n = 1'b1; tb_en = 1'b0; rd_n = 1'b0;
    #1 d = data;
    check("R8 drive during read", {7'b0, drv_on}, 8'h01);
    @(negedge clk);
    rd_n = 1'b1; tb_en = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] q;
    idle();
    #1 check("R3 deselected no drive", {7'b0, drv_on}, 8'h00);
    wr(5'd3, 8'h5A);
    rd(5'd3, q);
    check("R2 basic write", q, 8'h5A);
  endtask

  task automatic t_walk(input logic invert);
    logic [DW-1:0] q, p;
    for (int i = 0; i < N; i++) begin
      p = 8'h01 << (i % DW);
      if (invert) p = ~p;
      wr(i[AW-1:0], p);
    end
    for (int i = 0; i < N; i++) begin
      p = 8'h01 << (i % DW);
      if (invert) p = ~p;
      rd(i[AW-1:0], q);
      check(invert ? "R1 walking zeros" : "R1 walking ones", q, p);
    end
  endtask

  task automatic t_unique();
    logic [DW-1:0] q;
    for (int i = 0; i < N; i++) wr(i[AW-1:0], 8'(i * 7 + 3));
    for (int i = N - 1; i >= 0; i--) begin
      rd(i[AW-1:0], q);
      check("R1 unique per address", q, 8'(i * 7 + 3));
    end
  endtask

  task automatic t_comb_read();
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b1; tb_en = 1'b0; rd_n = 1'b0; addr = 5'd4;
    #1 check("R4 read addr 4", data, 8'(4 * 7 + 3));
    addr = 5'd9;
    #1 check("R4 address change without edge", data, 8'(9 * 7 + 3));
    wr_n = 1'b0;
    #1 check("R4 read with write strobe low", data, 8'(9 * 7 + 3));
    @(posedge clk);
    @(negedge clk);
    #1 check("R5 both strobes, word held", data, 8'(9 * 7 + 3));
    idle();
  endtask

  task automatic t_deselect_write();
    logic [DW-1:0] q;
    wr(5'd12, 8'hC3);
    @(negedge clk);
    tb_en = 1'b1; tb_val = 8'h3C; addr = 5'd12;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b0;
    #1 check("R3 no drive with strobes, deselected", {7'b0, drv_on}, 8'h00);
    rd_n = 1'b0;
    #1 check("R3 read strobe ignored when deselected", {7'b0, drv_on}, 8'h00);
    rd_n = 1'b1;
    @(posedge clk);
    idle();
    rd(5'd12, q);
    check("R3 write ignored when deselected", q, 8'hC3);
  endtask

  task automatic t_standby();
    logic [DW-1:0] q;
    wr(5'd20, 8'h81);
    @(negedge clk);
    tb_en = 1'b1; tb_val = 8'h7E; addr = 5'd20;
    cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    #1 check("R6 standby no drive", {7'b0, drv_on}, 8'h00);
    @(posedge clk);
    @(posedge clk);
    rd(5'd20, q);
    check("R6 standby keeps word", q, 8'h81);
  endtask

  task automatic t_raw();
    logic [DW-1:0] q;
    wr(5'd31, 8'hA5);
    rd(5'd31, q);
    check("R7 read after write", q, 8'hA5);
    wr(5'd31, 8'h96);
    rd(5'd31, q);
    check("R7 overwrite then read", q, 8'h96);
    rd(5'd30, q);
    check("R7 neighbour untouched", q, 8'(30 * 7 + 3));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_walk(1'b0);
    t_walk(1'b1);
    t_unique();
    t_comb_read();
    t_deselect_write();
    t_standby();
    t_raw();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule